// File: doc/BRIEF.md
# UART Channel Interrupt Prioritizer

This block decides which interrupt a single serial channel presents to the processor and builds the identification byte that software reads to learn the cause. Five condition requests arrive from the channel's status logic: a receive line error, receive data at the trigger level, a receive character timeout, a transmit holding register that has gone empty, and a modem status change. A 4-bit enable register gates them. The highest-ranked enabled request is encoded into the low nibble of the byte, and a registered interrupt line is raised whenever any enabled request is pending.

The block also owns the transmit-empty pending latch. The latch is set by a rising edge of the holding-empty level, or when FIFO mode is switched on while the holding register is empty. A write to the holding register clears it. So does the end of a read of the identification byte, when the byte that was read named transmit-empty as the cause. While `id_rd` is high the byte stays frozen. Requests keep being recorded in that time, and the byte is refreshed when the read ends.

All state uses a synchronous, active-high reset. Changes on the inputs presented before a rising edge appear on `irq_out` and `id_byte` at that edge.

Top module: `uirq_prioritizer`

## Requirements
- R1: Ranking, highest first: line error (enable bit 2), then receive data or timeout (enable bit 0), then transmit-empty (enable bit 1), then modem change (enable bit 3). Only the highest-ranked enabled request is encoded.
- R2: Bit 0 of `id_byte` is 1 when no enabled request is pending and 0 otherwise.
- R3: The low nibble is 0110 for a line error, 0100 for receive data, 1100 for a timeout, 0010 for transmit-empty and 0000 for a modem change.
- R4: A timeout is considered only while `fifo_mode` is 1, so bit 3 is never set without bit 2. When receive data and a timeout are requested together, receive data (0100) is shown.
- R5: Bits 5:4 always read 00. Bits 7:6 read 11 while `fifo_mode` is 1 and 00 while it is 0.
- R6: While `id_rd` is high at a rising edge, `id_byte` holds its value. Requests that arrive during the read are reflected after the read ends.
- R7: The transmit-empty latch is set by a 0-to-1 change of `thr_empty` and cleared by `thr_wr`.
- R8: When `id_rd` falls, the latch is cleared if the held byte showed 0010. If the held byte showed any other cause, the latch is kept.
- R9: A 0-to-1 change of `fifo_mode` while `thr_empty` is 1 sets the transmit-empty latch immediately.
- R10: Each enable bit gates only its own sources: bit 0 gates receive data and timeout, bit 1 transmit-empty, bit 2 line error, bit 3 modem change. The transmit-empty latch keeps its state while its enable bit is 0.
- R11: `irq_out` is 1 exactly when an enabled request is pending. It is registered, so it changes at the same edge as the byte.
- R12: A write through `en_wr`/`en_wdata` loads the enable register at the next rising edge. The outputs reflect the new enables from the edge after that.
- R13: A same-cycle `thr_wr` overrides a new transmit-empty set. A new set overrides a read-completion clear.
- R14: After reset, `id_byte` is 0x01, `irq_out` is 0, all enables are 0 and the latch is clear. Edge detection starts from the values seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFO mode is enabled |
| req_line | input | 1 | Receive line error request |
| req_rxd | input | 1 | Receive data at trigger level request |
| req_tmo | input | 1 | Receive character timeout request |
| req_modem | input | 1 | Modem status change request |
| thr_empty | input | 1 | Holding register empty level |
| thr_wr | input | 1 | Holding register write strobe |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable register write data |
| id_rd | input | 1 | Identification byte read in progress |
| irq_out | output | 1 | Registered interrupt request |
| id_byte | output | 8 | Identification byte |

## Verification
Two kinds of collision can land on the same clock edge. In the first, a holding-register write arrives in the same cycle as a new rising edge of `thr_empty`. In the second, the end of a read whose held byte showed transmit-empty coincides with a fresh rise of `thr_empty`. The bench drives both collisions on purpose. It checks that the write wins in the first case and that the new set wins in the second, by observing whether 0010 appears in the byte on the edges that follow. A behavioural reference model is compared with both outputs on every clock, and this covers the freeze windows and the enable-change timing as well.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int EN_W  = 4;
    localparam int ID_W  = 8;
    localparam int SRC_W = 4;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE  = 4'b0001,
        SRC_LINE  = 4'b0110,
        SRC_RXD   = 4'b0100,
        SRC_TMO   = 4'b1100,
        SRC_THRE  = 4'b0010,
        SRC_MODEM = 4'b0000
    } src_code_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tmo;
        logic thre;
        logic modem;
    } req_s;

    function automatic src_code_e pick_src(req_s r);
        src_code_e c;
        if (r.line)       c = SRC_LINE;
        else if (r.rxd)   c = SRC_RXD;
        else if (r.tmo)   c = SRC_TMO;
        else if (r.thre)  c = SRC_THRE;
        else if (r.modem) c = SRC_MODEM;
        else              c = SRC_NONE;
        return c;
    endfunction

    function automatic logic [ID_W-1:0] build_id(src_code_e c, logic fifo);
        return {{2{fifo}}, 2'b00, c};
    endfunction

endpackage

// File: rtl/uirq_en_reg.sv
module uirq_en_reg
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en
);
    for (genvar i = 0; i < EN_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)     en[i] <= 1'b0;
            else if (wr) en[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/uirq_thre_latch.sv
module uirq_thre_latch (
    input  logic clk,
    input  logic rst,
    input  logic empty,
    input  logic fifo_mode,
    input  logic thr_wr,
    input  logic rd_done,
    input  logic shown_thre,
    output logic pend_next
);
    logic pend_q;
    logic empty_q;
    logic fifo_q;
    logic set_ev;
    logic clr_rd;

    always_comb begin
        set_ev = (empty & ~empty_q) | (fifo_mode & ~fifo_q & empty);
        clr_rd = rd_done & shown_thre;
        if (thr_wr)      pend_next = 1'b0;
        else if (set_ev) pend_next = 1'b1;
        else if (clr_rd) pend_next = 1'b0;
        else             pend_next = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            empty_q <= 1'b1;
            fifo_q  <= 1'b1;
        end else begin
            pend_q  <= pend_next;
            empty_q <= empty;
            fifo_q  <= fifo_mode;
        end
    end
endmodule

// File: rtl/uirq_gate.sv
module uirq_gate
    import uirq_pkg::*;
(
    input  req_s            raw,
    input  logic [EN_W-1:0] en,
    input  logic            fifo_mode,
    output req_s            gated
);
    always_comb begin
        gated.line  = raw.line  & en[EN_LINE];
        gated.rxd   = raw.rxd   & en[EN_RX];
        gated.tmo   = raw.tmo   & en[EN_RX] & fifo_mode;
        gated.thre  = raw.thre  & en[EN_THRE];
        gated.modem = raw.modem & en[EN_MODEM];
    end
endmodule

// File: rtl/uirq_id_hold.sv
module uirq_id_hold
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  req_s            gated,
    input  logic            fifo_mode,
    input  logic            rd,
    output logic [ID_W-1:0] id_q,
    output logic            irq_q,
    output logic            rd_done,
    output logic            shown_thre
);
    logic            rd_q;
    logic [ID_W-1:0] live_id;
    logic            live_irq;

    always_comb begin
        live_id  = build_id(pick_src(gated), fifo_mode);
        live_irq = |gated;
    end

    assign rd_done    = rd_q & ~rd;
    assign shown_thre = (id_q[SRC_W-1:0] == SRC_THRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= build_id(SRC_NONE, 1'b0);
            irq_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            rd_q  <= rd;
            irq_q <= live_irq;
            if (!rd) id_q <= live_id;
        end
    end
endmodule

// File: rtl/uirq_prioritizer.sv
module uirq_prioritizer
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_mode,
    input  logic            req_line,
    input  logic            req_rxd,
    input  logic            req_tmo,
    input  logic            req_modem,
    input  logic            thr_empty,
    input  logic            thr_wr,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            id_rd,
    output logic            irq_out,
    output logic [ID_W-1:0] id_byte
);
    logic [EN_W-1:0] en;
    logic            thre_pend;
    logic            rd_done;
    logic            shown_thre;
    req_s            raw;
    req_s            gated;

    uirq_en_reg u_en (
        .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata), .en(en)
    );

    uirq_thre_latch u_thre (
        .clk(clk), .rst(rst), .empty(thr_empty), .fifo_mode(fifo_mode),
        .thr_wr(thr_wr), .rd_done(rd_done), .shown_thre(shown_thre),
        .pend_next(thre_pend)
    );

    always_comb begin
        raw.line  = req_line;
        raw.rxd   = req_rxd;
        raw.tmo   = req_tmo;
        raw.thre  = thre_pend;
        raw.modem = req_modem;
    end

    uirq_gate u_gate (
        .raw(raw), .en(en), .fifo_mode(fifo_mode), .gated(gated)
    );

    uirq_id_hold u_hold (
        .clk(clk), .rst(rst), .gated(gated), .fifo_mode(fifo_mode),
        .rd(id_rd), .id_q(id_byte), .irq_q(irq_out),
        .rd_done(rd_done), .shown_thre(shown_thre)
    );
endmodule

// File: rtl/uirq_prioritizer_chk.sv
module uirq_prioritizer_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_mode,
    input logic       id_rd,
    input logic       thr_wr,
    input logic       irq_out,
    input logic [7:0] id_byte
);
    AST_FROZEN_READ: assert property (@(posedge clk) disable iff (rst)
        ($past(id_rd) && !$past(rst)) |-> $stable(id_byte)); // R6

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(id_rd) && !$past(rst)) |-> (irq_out == !id_byte[0])); // R11

    AST_TMO_PAIRED: assert property (@(posedge clk) disable iff (rst)
        id_byte[3] |-> (id_byte[2] && id_byte[7:6] == 2'b11)); // R4

    AST_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
        (!$past(id_rd) && !$past(rst)) |->
        (id_byte[7:6] == {2{$past(fifo_mode)}} && id_byte[5:4] == 2'b00)); // R5

    AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(thr_wr) && !$past(id_rd) && !$past(rst)) |->
        (id_byte[3:0] != 4'b0010)); // R7
endmodule

bind uirq_prioritizer uirq_prioritizer_chk u_chk (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .id_rd(id_rd),
    .thr_wr(thr_wr), .irq_out(irq_out), .id_byte(id_byte)
);

// File: tb/uirq_prioritizer_tb.sv
module uirq_prioritizer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       req_line = 1'b0, req_rxd = 1'b0, req_tmo = 1'b0, req_modem = 1'b0;
    logic       thr_empty = 1'b0, thr_wr = 1'b0;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = 4'h0;
    logic       id_rd = 1'b0;
    logic       irq_out;
    logic [7:0] id_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uirq_prioritizer u_dut (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .req_line(req_line),
        .req_rxd(req_rxd), .req_tmo(req_tmo), .req_modem(req_modem),
        .thr_empty(thr_empty), .thr_wr(thr_wr), .en_wr(en_wr),
        .en_wdata(en_wdata), .id_rd(id_rd), .irq_out(irq_out), .id_byte(id_byte)
    );

    // behavioural reference model
    logic [3:0] m_en;
    logic       m_thre, m_pe, m_pf, m_prd, m_irq, m_rdd, m_set;
    logic [7:0] m_id;
    logic [3:0] m_code;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 4'h0; m_thre = 1'b0; m_pe = 1'b1; m_pf = 1'b1; m_prd = 1'b0;
            m_id = 8'h01; m_irq = 1'b0;
        end else begin
            m_rdd = m_prd && !id_rd;
            m_set = (thr_empty && !m_pe) || (fifo_mode && !m_pf && thr_empty);
            if (thr_wr)                              m_thre = 1'b0;
            else if (m_set)                          m_thre = 1'b1;
            else if (m_rdd && m_id[3:0] == 4'b0010) m_thre = 1'b0;
            m_irq = 1'b1;
            if (req_line && m_en[2])                   m_code = 4'b0110;
            else if (req_rxd && m_en[0])               m_code = 4'b0100;
            else if (req_tmo && m_en[0] && fifo_mode)  m_code = 4'b1100;
            else if (m_thre && m_en[1])                m_code = 4'b0010;
            else if (req_modem && m_en[3])             m_code = 4'b0000;
            else begin m_code = 4'b0001; m_irq = 1'b0; end
            if (!id_rd) m_id = {fifo_mode, fifo_mode, 2'b00, m_code};
            if (en_wr) m_en = en_wdata;
            m_pe = thr_empty; m_pf = fifo_mode; m_prd = id_rd;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (id_byte !== m_id) begin
                errors++;
                $display("FAIL R3 model id: actual=%h expected=%h", id_byte, m_id);
            end
            checks++;
            if (irq_out !== m_irq) begin
                errors++;
                $display("FAIL R11 model irq: actual=%b expected=%b", irq_out, m_irq);
            end
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] exp_id, logic exp_irq);
        checks++;
        if (id_byte !== exp_id || irq_out !== exp_irq) begin
            errors++;
            $display("FAIL %s: actual id=%h irq=%b expected id=%h irq=%b",
                     tag, id_byte, irq_out, exp_id, exp_irq);
        end
    endtask

    task automatic write_en(logic [3:0] v);
        en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick();
        chk("R14 reset", 8'h01, 1'b0);
        write_en(4'hF);
        req_modem = 1'b1; tick();
        chk("R3 modem", 8'h00, 1'b1);
        req_line = 1'b1; req_rxd = 1'b1; tick();
        chk("R1 line first", 8'h06, 1'b1);
        req_line = 1'b0; tick();
        chk("R1 rx next", 8'h04, 1'b1);
        req_rxd = 1'b0; req_tmo = 1'b1; tick();
        chk("R4 tmo ignored non fifo", 8'h00, 1'b1);
        fifo_mode = 1'b1; tick();
        chk("R4 tmo fifo", 8'hCC, 1'b1);
        req_rxd = 1'b1; tick();
        chk("R4 rx over tmo", 8'hC4, 1'b1);
        req_rxd = 1'b0; req_tmo = 1'b0; req_modem = 1'b0; tick();
        chk("R2 idle fifo R5", 8'hC1, 1'b0);
        thr_empty = 1'b1; tick();
        chk("R7 set", 8'hC2, 1'b1);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        chk("R7 clear", 8'hC1, 1'b0);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        chk("R7 set again", 8'hC2, 1'b1);
        id_rd = 1'b1; tick(); req_line = 1'b1; tick(2);
        chk("R6 frozen", 8'hC2, 1'b1);
        id_rd = 1'b0; req_line = 1'b0; tick();
        chk("R8 read clears", 8'hC1, 1'b0);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        req_modem = 1'b1; tick();
        chk("R1 thre over modem", 8'hC2, 1'b1);
        req_line = 1'b1; tick();
        chk("R1 line over thre", 8'hC6, 1'b1);
        id_rd = 1'b1; tick(); req_line = 1'b0; tick();
        chk("R6 frozen line", 8'hC6, 1'b1);
        id_rd = 1'b0; tick();
        chk("R8 kept", 8'hC2, 1'b1);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        thr_empty = 1'b0; tick();
        thr_empty = 1'b1; thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        chk("R13 write wins", 8'hC0, 1'b1);
        tick();
        chk("R13 no late set", 8'hC0, 1'b1);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        id_rd = 1'b1; tick(); thr_empty = 1'b0; tick();
        id_rd = 1'b0; thr_empty = 1'b1; tick();
        chk("R13 set wins over read clear", 8'hC2, 1'b1);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        fifo_mode = 1'b0; tick();
        chk("R5 non fifo", 8'h00, 1'b1);
        fifo_mode = 1'b1; tick();
        chk("R9 fifo enable sets", 8'hC2, 1'b1);
        en_wr = 1'b1; en_wdata = 4'b1000; tick(); en_wr = 1'b0;
        chk("R12 old enables", 8'hC2, 1'b1);
        tick();
        chk("R10 modem only", 8'hC0, 1'b1);
        write_en(4'b0001); tick();
        chk("R10 rx only none", 8'hC1, 1'b0);
        write_en(4'b0010); tick();
        chk("R10 latch kept", 8'hC2, 1'b1);
        write_en(4'h0); tick();
        chk("R11 all off", 8'hC1, 1'b0);
        tick(2);
        finish_run();
    end
endmodule